// File: doc/BRIEF.md
# Masked Packed-Element Word ALU

This unit takes one 32-bit slice of a vector register and treats it as a group of packed elements. Each element is 8, 16 or 32 bits wide, and a three-bit width code picks the width on every operation. An upstream sequencer feeds the unit one word per operation. With each word it supplies the first operand word, the second operand and the old destination word. It also supplies the slice of mask bits that belongs to this word and the number of elements still left in the vector. One cycle later the unit returns the new destination word, with every element merged according to masking and tail rules.

The second operand is either a full word, split into elements like the first operand, or a single value. A single value is a scalar or a sign-extended immediate prepared by the decoder, and its low element bits are applied to every element. An element that is masked off, or that lies beyond the end of the vector, keeps its old destination bits. A width code or operation code the unit does not support leaves the whole word unchanged.

Top module: `packed_lane_alu`

## Requirements
- R1: `sewField` (bits [5:3] of the vector type register) selects the element width as 8 << sewField. Code 0 gives four 8-bit elements, code 1 gives two 16-bit elements and code 2 gives one 32-bit element. Element k occupies bits [k*w +: w].
- R2: When `sewField` is 3 to 7, the result equals `oldDest`.
- R3: When `maskOff` is 1, every active element takes its computed result, whatever the mask bits are.
- R4: When `maskOff` is 0, element k takes its computed result if `maskBits[k]` is 1 and keeps its `oldDest` bits if `maskBits[k]` is 0.
- R5: Each element result is truncated to the element width, so add and subtract wrap modulo 2^w and no carry crosses into a neighbouring element.
- R6: `opCode` encoding: 0 add, 1 subtract (a-b), 3 and, 4 or, 5 xor, 8 multiply (low w bits of the product). Codes 9 to 15 leave the word equal to `oldDest`.
- R7: Code 2 (reverse subtract) gives b - a per element.
- R8: Code 6 (move) writes the second operand into each element and ignores `srcA`.
- R9: Only elements with index below `remCount` are computed. The elements above that index keep their `oldDest` bits, and when `remCount` is 0 the whole word equals `oldDest`.
- R10: Code 7 shifts the element left by the second operand ANDed with w-1. Only the low log2(w) bits of the amount count.
- R11: When `bcastEn` is 1, the low w bits of `srcB` are the second operand of every element. When it is 0, element k of `srcB` pairs with element k of `srcA`.
- R12: `resultWord` and `resultValid` update on the clock edge after `opValid` is sampled high. While `opValid` is low, `resultWord` holds and `resultValid` is 0. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation select |
| sewField | input | 3 | Element width code |
| bcastEn | input | 1 | Second operand is one value shared by all elements |
| srcA | input | 32 | First operand word |
| srcB | input | 32 | Second operand word or scalar/immediate value |
| oldDest | input | 32 | Current destination word |
| maskBits | input | 4 | Mask bit per element of this word |
| maskOff | input | 1 | 1 disables masking |
| remCount | input | 8 | Elements remaining from this word onward |
| resultWord | output | 32 | New destination word |
| resultValid | output | 1 | resultWord was updated by the last edge |

## Verification
The assertions check several properties on every cycle. They check that the valid output follows the request one edge later and that the output holds when idle. They also check that an unsupported width code or a zero remaining count returns the old destination untouched, that a masked-off first element keeps its old bits, and that an unmasked full-word move copies the second operand. The arithmetic of each operation is shown only by the bench's scenarios. So are the wrap without cross-element carry, the shift-amount clipping, the broadcast and the partial-word boundaries at every width. The bench compares those against its own reference model over random and directed words.

// File: rtl/plw_pkg.sv
package plw_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int LANE_IW = $clog2(LANES);

  typedef enum logic [1:0] {
    WID8    = 2'd0,
    WID16   = 2'd1,
    WID32   = 2'd2,
    WIDNONE = 2'd3
  } width_e;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_RSUB = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_MOVE = 4'd6;
  localparam logic [3:0] OP_SLL  = 4'd7;
  localparam logic [3:0] OP_MUL  = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    width_e           widthSel;
    logic [3:0]       opCode;
    logic [LANES-1:0] byteTake;  // 1: byte takes computed value
  } plw_ctrl_t;
endpackage

// File: rtl/plw_elem_op.sv
module plw_elem_op #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   opCode,
  output logic [W-1:0] res
);
  import plw_pkg::*;
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shAmt;
  assign shAmt = opB[SH_W-1:0];

  always_comb begin
    case (opCode)
      OP_ADD:  res = opA + opB;
      OP_SUB:  res = opA - opB;
      OP_RSUB: res = opB - opA;
      OP_AND:  res = opA & opB;
      OP_OR:   res = opA | opB;
      OP_XOR:  res = opA ^ opB;
      OP_MOVE: res = opB;
      OP_SLL:  res = opA << shAmt;
      OP_MUL:  res = opA * opB;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/plw_ctrl.sv
module plw_ctrl
  import plw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       sewField,
  input  logic [3:0]       opCode,
  input  logic [LANES-1:0] maskBits,
  input  logic             maskOff,
  input  logic [CNT_W-1:0] remCount,
  output plw_ctrl_t        ctrl
);
  logic widthOk;
  logic opOk;

  always_comb begin
    case (sewField)
      3'd0:    ctrl.widthSel = WID8;
      3'd1:    ctrl.widthSel = WID16;
      3'd2:    ctrl.widthSel = WID32;
      default: ctrl.widthSel = WIDNONE;
    endcase
    widthOk     = (ctrl.widthSel != WIDNONE);
    opOk        = (opCode <= OP_MUL);
    ctrl.opCode = opCode;
  end

  // element index of each byte lane = lane >> width code
  for (genvar b = 0; b < LANES; b++) begin : g_take
    logic [LANE_IW-1:0] elemIdx;
    logic               inRange;
    logic               maskPass;
    always_comb begin
      elemIdx  = LANE_IW'(b) >> sewField[1:0];
      inRange  = (CNT_W'(elemIdx) < remCount);
      maskPass = maskOff | maskBits[elemIdx];
      ctrl.byteTake[b] = widthOk & opOk & inRange & maskPass;
    end
  end
endmodule

// File: rtl/plw_datapath.sv
module plw_datapath
  import plw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  plw_ctrl_t         ctrl,
  input  logic              bcastEn,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] oldDest,
  output logic [WORD_W-1:0] resultWord,
  output logic              resultValid
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;

  logic [WORD_W-1:0] word8, word16, word32, newWord, mergedWord;

  for (genvar g = 0; g < N8; g++) begin : g_e8
    logic [7:0] bOp;
    assign bOp = bcastEn ? srcB[7:0] : srcB[8*g +: 8];
    plw_elem_op #(.W(8)) u_op (
      .opA(srcA[8*g +: 8]), .opB(bOp), .opCode(ctrl.opCode), .res(word8[8*g +: 8]));
  end

  for (genvar g = 0; g < N16; g++) begin : g_e16
    logic [15:0] bOp;
    assign bOp = bcastEn ? srcB[15:0] : srcB[16*g +: 16];
    plw_elem_op #(.W(16)) u_op (
      .opA(srcA[16*g +: 16]), .opB(bOp), .opCode(ctrl.opCode), .res(word16[16*g +: 16]));
  end

  for (genvar g = 0; g < N32; g++) begin : g_e32
    logic [31:0] bOp;
    assign bOp = bcastEn ? srcB[31:0] : srcB[32*g +: 32];
    plw_elem_op #(.W(32)) u_op (
      .opA(srcA[32*g +: 32]), .opB(bOp), .opCode(ctrl.opCode), .res(word32[32*g +: 32]));
  end

  always_comb begin
    case (ctrl.widthSel)
      WID8:    newWord = word8;
      WID16:   newWord = word16;
      WID32:   newWord = word32;
      default: newWord = oldDest;
    endcase
  end

  for (genvar b = 0; b < N8; b++) begin : g_merge
    assign mergedWord[8*b +: 8] = ctrl.byteTake[b] ? newWord[8*b +: 8] : oldDest[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultWord  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= opValid;
      if (opValid) resultWord <= mergedWord;
    end
  end

  // R12: idle cycles leave the output word alone
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(resultWord));
  // R12: valid follows the request by one edge
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resultValid);
  a_r12_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultValid);
endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
  import plw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [2:0]        sewField,
  input  logic              bcastEn,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] oldDest,
  input  logic [LANES-1:0]  maskBits,
  input  logic              maskOff,
  input  logic [CNT_W-1:0]  remCount,
  output logic [WORD_W-1:0] resultWord,
  output logic              resultValid
);
  plw_ctrl_t ctrl;

  plw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .sewField(sewField), .opCode(opCode), .maskBits(maskBits),
    .maskOff(maskOff), .remCount(remCount), .ctrl(ctrl));

  plw_datapath u_dp (
    .clk(clk), .rstN(rstN), .opValid(opValid), .ctrl(ctrl), .bcastEn(bcastEn),
    .srcA(srcA), .srcB(srcB), .oldDest(oldDest),
    .resultWord(resultWord), .resultValid(resultValid));

  // R2: unsupported width code keeps the old word
  a_r2_bad_width_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && sewField > 3'd2) |=> resultWord == $past(oldDest));
  // R9: nothing left to compute keeps the old word
  a_r9_zero_count_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && remCount == '0) |=> resultWord == $past(oldDest));
  // R4: element 0 masked off keeps its low byte at every width
  a_r4_masked_elem0_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !maskOff && !maskBits[0]) |=> resultWord[7:0] == $past(oldDest[7:0]));
  // R8: unmasked full-word move copies the second operand
  a_r8_move_copies: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_MOVE && maskOff && sewField == 3'd2 && remCount != '0)
      |=> resultWord == $past(srcB));
endmodule

// File: tb/packed_lane_alu_tb.sv
module packed_lane_alu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [2:0]  sewField = '0;
  logic        bcastEn = 1'b0;
  logic [31:0] srcA = '0, srcB = '0, oldDest = '0;
  logic [3:0]  maskBits = '0;
  logic        maskOff = 1'b1;
  logic [7:0]  remCount = '0;
  logic [31:0] resultWord;
  logic        resultValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  packed_lane_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .sewField(sewField),
    .bcastEn(bcastEn), .srcA(srcA), .srcB(srcB), .oldDest(oldDest), .maskBits(maskBits),
    .maskOff(maskOff), .remCount(remCount), .resultWord(resultWord), .resultValid(resultValid));

  function automatic logic [31:0] refModel(
    logic [3:0] op, logic [2:0] sew, logic bc, logic [31:0] a, logic [31:0] b,
    logic [31:0] od, logic [3:0] mk, logic mo, logic [7:0] rem);
    logic [31:0] res;
    int w, n;
    logic [63:0] m, ea, eb, r;
    res = od;
    if (sew > 3'd2 || op > 4'd8) return od;
    w = 8 << sew;
    n = 32 / w;
    m = (64'd1 << w) - 64'd1;
    for (int k = 0; k < n; k++) begin
      if (k < int'(rem) && (mo || mk[k])) begin
        ea = (64'(a) >> (k * w)) & m;
        eb = bc ? (64'(b) & m) : ((64'(b) >> (k * w)) & m);
        case (op)
          4'd0: r = ea + eb;
          4'd1: r = ea - eb;
          4'd2: r = eb - ea;
          4'd3: r = ea & eb;
          4'd4: r = ea | eb;
          4'd5: r = ea ^ eb;
          4'd6: r = eb;
          4'd7: r = ea << (eb & 64'(w - 1));
          default: r = ea * eb;
        endcase
        res = (res & ~32'(m << (k * w))) | 32'((r & m) << (k * w));
      end
    end
    return res;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic runOp(string req, logic [3:0] op, logic [2:0] sew, logic bc,
                       logic [31:0] a, logic [31:0] b, logic [31:0] od,
                       logic [3:0] mk, logic mo, logic [7:0] rem);
    @(negedge clk);
    opValid = 1'b1; opCode = op; sewField = sew; bcastEn = bc;
    srcA = a; srcB = b; oldDest = od; maskBits = mk; maskOff = mo; remCount = rem;
    @(posedge clk); #1;
    check(req, resultWord, refModel(op, sew, bc, a, b, od, mk, mo, rem));
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset word", resultWord, 32'h0);
    check("R12 reset valid", {31'd0, resultValid}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R5 R1: 8-bit wrap, no carry between elements
    runOp("R5 add8 wrap", 4'd0, 3'd0, 1'b0, 32'hFF7F01FF, 32'h01810101, 32'h0, 4'h0, 1'b1, 8'd4);
    check("R5 add8 exact", resultWord, 32'h00000200);
    runOp("R1 add16", 4'd0, 3'd1, 1'b0, 32'hFFFF1234, 32'h00010001, 32'h0, 4'h0, 1'b1, 8'd2);
    check("R1 add16 exact", resultWord, 32'h00001235);
    runOp("R1 add32", 4'd0, 3'd2, 1'b0, 32'hFFFFFFFF, 32'h2, 32'h0, 4'h0, 1'b1, 8'd1);
    runOp("R6 sub8", 4'd1, 3'd0, 1'b0, 32'h00050A10, 32'h01060305, 32'h0, 4'h0, 1'b1, 8'd4);
    runOp("R7 rsub16", 4'd2, 3'd1, 1'b0, 32'h00030010, 32'h00010030, 32'h0, 4'h0, 1'b1, 8'd2);
    check("R7 rsub16 exact", resultWord, 32'hFFFE0020);
    runOp("R6 and", 4'd3, 3'd0, 1'b0, 32'hF0F0AAAA, 32'hFF0F0F55, 32'h0, 4'h0, 1'b1, 8'd4);
    runOp("R6 or", 4'd4, 3'd1, 1'b0, 32'h12340000, 32'h00005678, 32'h0, 4'h0, 1'b1, 8'd2);
    runOp("R6 xor", 4'd5, 3'd2, 1'b0, 32'hDEADBEEF, 32'hFFFF0000, 32'h0, 4'h0, 1'b1, 8'd1);
    runOp("R6 mul16", 4'd8, 3'd1, 1'b0, 32'h01000300, 32'h01000005, 32'h0, 4'h0, 1'b1, 8'd2);
    check("R6 mul16 exact", resultWord, 32'h00000F00);
    runOp("R8 move ignores srcA", 4'd6, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h11223344, 32'h0, 4'h0, 1'b1, 8'd4);
    check("R8 move exact", resultWord, 32'h11223344);
    // R10: amount 9 at width 8 shifts by 1
    runOp("R10 sll8 clip", 4'd7, 3'd0, 1'b1, 32'h81404001, 32'h00000009, 32'h0, 4'h0, 1'b1, 8'd4);
    check("R10 sll8 exact", resultWord, 32'h02808002);
    runOp("R10 sll16 clip", 4'd7, 3'd1, 1'b0, 32'h00010001, 32'h00110004, 32'h0, 4'h0, 1'b1, 8'd2);
    // R11 broadcast
    runOp("R11 bcast add8", 4'd0, 3'd0, 1'b1, 32'h01020304, 32'hAAAA0010, 32'h0, 4'h0, 1'b1, 8'd4);
    check("R11 bcast exact", resultWord, 32'h11121314);
    // R3 masks ignored when maskOff
    runOp("R3 mask ignored", 4'd6, 3'd0, 1'b0, 32'h0, 32'h55555555, 32'hAAAAAAAA, 4'h0, 1'b1, 8'd4);
    // R4 masking
    runOp("R4 mask8", 4'd6, 3'd0, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'b0101, 1'b0, 8'd4);
    check("R4 mask8 exact", resultWord, 32'hAA22CC44);
    runOp("R4 mask16", 4'd6, 3'd1, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'b1110, 1'b0, 8'd2);
    check("R4 mask16 exact", resultWord, 32'h1122CCDD);
    // R9 partial words
    runOp("R9 rem1", 4'd6, 3'd0, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'h0, 1'b1, 8'd1);
    check("R9 rem1 exact", resultWord, 32'hAABBCC44);
    runOp("R9 rem3", 4'd6, 3'd0, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'h0, 1'b1, 8'd3);
    runOp("R9 rem1 w16", 4'd6, 3'd1, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'h0, 1'b1, 8'd1);
    runOp("R9 rem0", 4'd6, 3'd2, 1'b0, 32'h0, 32'h11223344, 32'hAABBCCDD, 4'h0, 1'b1, 8'd0);
    check("R9 rem0 exact", resultWord, 32'hAABBCCDD);
    // R2 unsupported width, R6 unsupported op
    runOp("R2 bad width", 4'd0, 3'd3, 1'b0, 32'h1, 32'h1, 32'h600DF00D, 4'hF, 1'b1, 8'd4);
    check("R2 bad width exact", resultWord, 32'h600DF00D);
    runOp("R6 bad op", 4'd12, 3'd0, 1'b0, 32'h1, 32'h1, 32'hC0FFEE00, 4'hF, 1'b1, 8'd4);

    // R12 hold while idle
    held = resultWord;
    @(negedge clk);
    srcA = 32'h12345678; oldDest = 32'h87654321;
    @(posedge clk); #1;
    check("R12 idle hold", resultWord, held);
    check("R12 idle valid low", {31'd0, resultValid}, 32'h0);

    // random mix, all requirements
    for (int i = 0; i < 1500; i++) begin
      runOp("R1-mix random", 4'($urandom_range(0, 9)), 3'($urandom_range(0, 3)),
            1'($urandom), $urandom, $urandom, $urandom, 4'($urandom),
            1'($urandom), 8'($urandom_range(0, 5)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule